// File: doc/BRIEF.md
# Bit-Oriented Receive Deframer

This block sits at the front of a bit-oriented (HDLC/SDLC style) serial receiver. Each recovered line bit arrives on `bit_in` with a one-cycle `bit_valid` strobe. The block counts runs of ones to tell a stuffed zero, a flag and a seven-ones pattern apart. It deletes the inserted zeros and aligns octets to each flag. The octets go to a downstream CRC-CCITT checker, and every octet between two flags is delivered.

After reset the receiver hunts. It emits no data until the first flag (`01111110`) is seen. From then on, destuffed data bits are released through a short delay line. Bits that turn out to belong to a flag or to an abort pattern are therefore never passed on. The released bits are packed into octets, first-received bit in bit 0. A closing flag after data gives an end-of-frame pulse. Seven ones in a row send the receiver back to hunt. In normal mode this reports an abort; with `loop_mode` high it reports end-of-poll.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While reset is asserted and at the first sample after it, every output strobe is low, `octet_data` is zero and the receiver is hunting.
- R2: While hunting, no data bit strobe and no octet is produced. A flag is reported on `flag_pulse` and ends the hunt.
- R3: A zero that follows exactly five ones is deleted and produces no data bit. It also clears the ones count, so payloads with long runs of ones are recovered exactly.
- R4: Octets are assembled from the destuffed bits with the first received bit in bit 0. `octet_valid` rises together with the data bit strobe of the eighth bit.
- R5: Flags sent back to back each give a `flag_pulse` but no octet and no `eof_pulse`.
- R6: A flag that follows at least one octet gives `eof_pulse` together with `flag_pulse`. No bit of any flag ever appears as data.
- R7: In normal mode (`loop_mode` = 0), a one that follows six ones gives a single `abort_pulse`. Further ones give no more pulses. The partial octet is dropped and the receiver hunts until the next flag.
- R8: With `loop_mode` = 1 the same seven-ones pattern gives `eop_pulse` instead of `abort_pulse`, with the same discard and return to hunt.
- R9: `bit_in` is ignored in cycles where `bit_valid` is low. Idle gaps of any length between bits do not change the received octets.
- R10: Every output strobe is registered. It appears in the clock cycle right after the accepted bit that causes it and lasts one cycle.
- R11: A destuffed data bit is released on `bit_out_valid` only once seven more candidate bits have been accepted. So eight data bits after a flag release exactly one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| loop_mode | input | 1 | 0: seven ones mean abort; 1: seven ones mean end-of-poll |
| bit_valid | input | 1 | Qualifies `bit_in` for one cycle |
| bit_in | input | 1 | Recovered serial line bit |
| bit_out_valid | output | 1 | Strobe for one destuffed data bit |
| bit_out | output | 1 | Destuffed data bit |
| octet_valid | output | 1 | Strobe for a completed octet |
| octet_data | output | 8 | Assembled octet, first bit in bit 0 |
| flag_pulse | output | 1 | A flag was received |
| eof_pulse | output | 1 | The flag closed a frame that carried data |
| abort_pulse | output | 1 | Seven ones seen in normal mode |
| eop_pulse | output | 1 | Seven ones seen in loop mode |

## Verification
A wrong ones count shows quickly. A deleted real one or a kept stuffed zero corrupts the octet that holds it. A missed flag or abort shows up at the next flag or run of ones. A release line of the wrong depth lets flag bits leak into an octet, or loses the last data bit. Either way, the octet value or count at the closing flag is wrong, within one frame. A stuck hunt or sync state shows at once: data strobes appear before any flag, or octets go missing after one.

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer #(
  parameter int OCTET_W   = 8,
  parameter int STUFF_RUN = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               loop_mode,
  input  logic               bit_valid,
  input  logic               bit_in,
  output logic               bit_out_valid,
  output logic               bit_out,
  output logic               octet_valid,
  output logic [OCTET_W-1:0] octet_data,
  output logic               flag_pulse,
  output logic               eof_pulse,
  output logic               abort_pulse,
  output logic               eop_pulse
);

  localparam int FLAG_RUN  = STUFF_RUN + 1;
  localparam int ABORT_RUN = STUFF_RUN + 2;
  localparam int DLY       = FLAG_RUN + 1;
  localparam int CW        = $clog2(ABORT_RUN + 1);
  localparam int DW        = $clog2(DLY + 1);
  localparam int BW        = $clog2(OCTET_W);

  localparam logic [CW-1:0] STUFF_C = CW'(STUFF_RUN);
  localparam logic [CW-1:0] FLAG_C  = CW'(FLAG_RUN);
  localparam logic [CW-1:0] SAT_C   = CW'(ABORT_RUN);
  localparam logic [DW-1:0] FULL_C  = DW'(DLY);
  localparam logic [BW-1:0] LAST_C  = BW'(OCTET_W - 1);

  logic [CW-1:0]      ones_q;
  logic               synced_q;
  logic [DLY-1:0]     dl_q;
  logic [DW-1:0]      dl_n_q;
  logic [OCTET_W-1:0] oct_q;
  logic [BW-1:0]      obits_q;
  logic               got_oct_q;

  wire is_zero  = bit_valid && !bit_in;
  wire is_one   = bit_valid &&  bit_in;
  wire flag_hit = is_zero && (ones_q == FLAG_C);
  wire seven    = is_one  && (ones_q == FLAG_C);
  wire flush    = flag_hit || seven;
  wire push     = synced_q && ((is_zero && ones_q < STUFF_C) ||
                               (is_one  && ones_q < FLAG_C));
  wire pop      = push && (dl_n_q == FULL_C);
  wire pop_bit  = dl_q[DLY-1];
  wire oct_done = pop && (obits_q == LAST_C);
  wire [OCTET_W-1:0] oct_next = {pop_bit, oct_q[OCTET_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= '0;
    end else if (is_zero) begin
      ones_q <= '0;
    end else if (is_one && ones_q != SAT_C) begin
      ones_q <= ones_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        synced_q <= 1'b0;
    else if (flag_hit) synced_q <= 1'b1;
    else if (seven)    synced_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q   <= '0;
      dl_n_q <= '0;
    end else if (flush) begin
      dl_n_q <= '0;
    end else if (push) begin
      dl_q   <= {dl_q[DLY-2:0], bit_in};
      dl_n_q <= pop ? dl_n_q : dl_n_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oct_q     <= '0;
      obits_q   <= '0;
      got_oct_q <= 1'b0;
    end else begin
      if (flush || !synced_q) begin
        obits_q <= '0;
      end else if (pop) begin
        oct_q   <= oct_next;
        obits_q <= oct_done ? '0 : obits_q + 1'b1;
      end
      if (flush)         got_oct_q <= 1'b0;
      else if (oct_done) got_oct_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out_valid <= 1'b0;
      bit_out       <= 1'b0;
      octet_valid   <= 1'b0;
      octet_data    <= '0;
      flag_pulse    <= 1'b0;
      eof_pulse     <= 1'b0;
      abort_pulse   <= 1'b0;
      eop_pulse     <= 1'b0;
    end else begin
      bit_out_valid <= pop;
      bit_out       <= pop ? pop_bit : bit_out;
      octet_valid   <= oct_done;
      octet_data    <= oct_done ? oct_next : octet_data;
      flag_pulse    <= flag_hit;
      eof_pulse     <= flag_hit && synced_q && got_oct_q;
      abort_pulse   <= seven && !loop_mode;
      eop_pulse     <= seven &&  loop_mode;
    end
  end

  // R2
  hunt_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !synced_q |=> !bit_out_valid && !octet_valid);

  // R4
  octet_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    octet_valid |-> bit_out_valid);

  // R6
  eof_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> flag_pulse && !bit_out_valid);

  // R7
  status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_pulse, abort_pulse, eop_pulse}));

  // R8
  abort_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> !$past(loop_mode));

  // R10
  strobe_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_out_valid || flag_pulse || abort_pulse || eop_pulse) |-> $past(bit_valid));

  // R3
  stuffed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_zero && ones_q == STUFF_C) |=> ones_q == '0 && dl_n_q == $past(dl_n_q));

endmodule

// File: tb/tb_hdlc_rx_deframer.sv
module tb_hdlc_rx_deframer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic loop_mode = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_in = 1'b0;
  logic bit_out_valid, bit_out, octet_valid;
  logic [7:0] octet_data;
  logic flag_pulse, eof_pulse, abort_pulse, eop_pulse;

  hdlc_rx_deframer dut (
    .clk(clk), .rst_n(rst_n), .loop_mode(loop_mode),
    .bit_valid(bit_valid), .bit_in(bit_in),
    .bit_out_valid(bit_out_valid), .bit_out(bit_out),
    .octet_valid(octet_valid), .octet_data(octet_data),
    .flag_pulse(flag_pulse), .eof_pulse(eof_pulse),
    .abort_pulse(abort_pulse), .eop_pulse(eop_pulse)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int n_bits = 0, n_flag = 0, n_eof = 0, n_abort = 0, n_eop = 0;
  int gap = 0, tb_ones = 0;
  logic [7:0] oq[$];
  logic [7:0] pay[$];

  always @(negedge clk) if (rst_n) begin
    if (bit_out_valid) n_bits++;
    if (octet_valid) oq.push_back(octet_data);
    if (flag_pulse) n_flag++;
    if (eof_pulse) n_eof++;
    if (abort_pulse) n_abort++;
    if (eop_pulse) n_eop++;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1; bit_in = b;
    @(negedge clk);
    bit_valid = 1'b0; bit_in = ~b;
    repeat (gap) begin
      @(negedge clk);
      bit_in = ~bit_in;
    end
  endtask

  task automatic send_flag();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    send_bit(1'b0);
    tb_ones = 0;
  endtask

  task automatic send_raw_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) send_bit(b[i]);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      send_bit(b[i]);
      if (b[i]) begin
        tb_ones++;
        if (tb_ones == 5) begin send_bit(1'b0); tb_ones = 0; end
      end else tb_ones = 0;
    end
  endtask

  task automatic send_frame();
    send_flag();
    foreach (pay[i]) send_byte(pay[i]);
    send_flag();
    idle(3);
  endtask

  task automatic expect_octets(input string tag);
    check(oq.size() == pay.size(), {tag, " octet count"}, oq.size(), pay.size());
    if (oq.size() == pay.size())
      foreach (pay[i]) check(oq[i] == pay[i], {tag, " octet value"}, oq[i], pay[i]);
    oq.delete();
  endtask

  task automatic t_reset();
    check(!bit_out_valid && !octet_valid && !flag_pulse && !eof_pulse && !abort_pulse && !eop_pulse,
          "R1 strobes after reset", 1, 0);
    check(octet_data == 8'h00, "R1 octet_data after reset", octet_data, 0);
  endtask

  task automatic t_hunt();
    send_raw_byte(8'h55); send_raw_byte(8'h33);
    idle(3);
    check(n_bits == 0, "R2 no bits in hunt", n_bits, 0);
    check(oq.size() == 0, "R2 no octets in hunt", oq.size(), 0);
    check(n_flag == 0, "R2 no flag yet", n_flag, 0);
    send_flag(); idle(3);
    check(n_flag == 1, "R2 flag seen", n_flag, 1);
    check(n_bits == 0, "R2 flag bits not data", n_bits, 0);
  endtask

  task automatic t_release();
    int b0, e0;
    send_flag(); idle(2);
    b0 = n_bits; e0 = n_eof;
    send_byte(8'hC3); idle(3);
    check(n_bits - b0 == 1, "R11 one bit released", n_bits - b0, 1);
    send_flag(); idle(3);
    check(n_bits - b0 == 8, "R11 all data released at flag", n_bits - b0, 8);
    check(n_eof - e0 == 1, "R6 eof after data", n_eof - e0, 1);
    pay = '{8'hC3};
    expect_octets("R4 single octet");
  endtask

  task automatic t_frame();
    int b0, e0;
    b0 = n_bits; e0 = n_eof;
    pay = '{8'hA5, 8'h3C, 8'h01, 8'h80};
    send_frame();
    check(n_bits - b0 == 32, "R6 bit count excludes flags", n_bits - b0, 32);
    check(n_eof - e0 == 1, "R6 one eof", n_eof - e0, 1);
    expect_octets("R4 frame");
  endtask

  task automatic t_stuff();
    int b0;
    b0 = n_bits;
    pay = '{8'hFF, 8'hFF, 8'h7E, 8'h1F};
    send_frame();
    check(n_bits - b0 == 32, "R3 stuffed zeros removed", n_bits - b0, 32);
    expect_octets("R3 long ones");
  endtask

  task automatic t_b2b();
    int f0, e0;
    f0 = n_flag; e0 = n_eof;
    send_flag(); send_flag(); send_flag(); idle(3);
    check(n_flag - f0 == 3, "R5 three flags", n_flag - f0, 3);
    check(n_eof - e0 == 0, "R5 no eof", n_eof - e0, 0);
    check(oq.size() == 0, "R5 no octets", oq.size(), 0);
  endtask

  task automatic t_abort();
    int a0, p0, e0, b0;
    a0 = n_abort; p0 = n_eop; e0 = n_eof;
    send_flag(); send_byte(8'h12);
    repeat (4) send_bit(1'b0);
    repeat (10) send_bit(1'b1);
    idle(3);
    check(n_abort - a0 == 1, "R7 single abort", n_abort - a0, 1);
    check(n_eop - p0 == 0, "R7 no eop in normal mode", n_eop - p0, 0);
    check(n_eof - e0 == 0, "R7 no eof on abort", n_eof - e0, 0);
    pay = '{8'h12};
    expect_octets("R7 octets before abort");
    b0 = n_bits;
    send_raw_byte(8'h55); idle(3);
    check(n_bits == b0, "R7 hunting after abort", n_bits, b0);
    pay = '{8'h99};
    send_frame();
    expect_octets("R7 recovery");
  endtask

  task automatic t_loop();
    int a0, p0;
    a0 = n_abort; p0 = n_eop;
    loop_mode = 1'b1;
    send_flag(); send_byte(8'h0F);
    repeat (7) send_bit(1'b1);
    idle(3);
    check(n_eop - p0 == 1, "R8 eop in loop mode", n_eop - p0, 1);
    check(n_abort - a0 == 0, "R8 no abort in loop mode", n_abort - a0, 0);
    check(oq.size() == 0, "R8 partial octet dropped", oq.size(), 0);
    oq.delete();
    loop_mode = 1'b0;
  endtask

  task automatic t_gap();
    gap = 3;
    pay = '{8'h7E, 8'hE7, 8'h00};
    send_frame();
    gap = 0;
    expect_octets("R9 gaps with noise");
  endtask

  task automatic t_latency();
    send_bit(1'b0);
    repeat (6) send_bit(1'b1);
    @(negedge clk);
    bit_valid = 1'b1; bit_in = 1'b0;
    @(negedge clk);
    bit_valid = 1'b0;
    check(flag_pulse == 1'b1, "R10 flag next cycle", flag_pulse, 1);
    @(negedge clk);
    check(flag_pulse == 1'b0, "R10 flag one cycle", flag_pulse, 0);
    idle(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(4);
    check(!bit_out_valid && !flag_pulse && !octet_valid, "R1 strobes in reset", 1, 0);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_hunt();
    t_release();
    t_frame();
    t_stuff();
    t_b2b();
    t_abort();
    t_loop();
    t_gap();
    t_latency();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule